// File: doc/BRIEF.md
# ATA Register Cycle Sequencer

This block runs single host-side register accesses on an ATA/ATAPI parallel bus. A requester presents a direction, a five-bit register address and a write byte on a request/acknowledge port. The sequencer then drives the two active-low chip selects, the three address lines and either the read or the write strobe, and it keeps the DMA acknowledge negated. It returns the captured byte together with an error flag on a one-cycle response pulse. Every bus time is a parameter counted in cycles of the local clock. The defaults give slow-mode timing at a 4 ns clock: 250 cycles of address setup, a 75-cycle strobe, 225 cycles of address hold and recovery, and a 500-cycle full cycle.

The device can stretch a strobe through its ready line. That line passes through a two-stage synchronizer and is looked at once, a fixed number of cycles after the strobe is asserted. If the synchronized level is low at that point, the strobe stays asserted until the line returns high. A programmable limit on the number of wait cycles ends a cycle whose device never becomes ready, and the response then reports an error. Write data is driven only while the write strobe is asserted and for a short hold window after it.

Top module: `ata_reg_cycle_gen`

## Requirements
- R1: Address encoding: req_addr[4] selects chip select 1 (ata_cs1_n low), req_addr[3] selects chip select 0 (ata_cs0_n low), and req_addr[2:0] appears on ata_da. A request sets exactly one of bits 4:3. Both selects stay at the request's values from acceptance until the response, and both are high while idle.
- R2: ata_dmack_n is high at all times.
- R3: The strobe for the request's direction (ata_diow_n for writes, ata_dior_n for reads) goes low exactly T_SETUP (250) cycles after the acceptance edge. The other strobe stays high.
- R4: When the ready line is high at the check point, the strobe lasts exactly T_PULSE (75) cycles. A strobe ends no sooner than that unless the wait timeout ends it.
- R5: The ready line is checked T_CHK (9) cycles after the strobe is asserted, through a two-stage synchronizer. If it is low there, the strobe is negated exactly 3 cycles after the line rises, but never before T_PULSE cycles.
- R6: A low pulse on the ready line that is over before the check point adds no wait, and the strobe lasts T_PULSE cycles.
- R7: For a read, rsp_rdata holds the ata_dd_i byte present at the clock edge that negates ata_dior_n.
- R8: Address and selects stay valid for at least T_HOLD (225) cycles after the strobe ends. Consecutive strobes are at least T_REC (225) cycles apart.
- R9: The chip select stays asserted for at least T_CYCLE (500) cycles per access.
- R10: ata_dd_oe is high, with ata_dd_o equal to the write byte, from the cycle the write strobe is asserted through T_DHOLD (10) cycles after it is negated. At all other times, and for reads throughout, ata_dd_oe is low.
- R11: If the ready line stays low, the strobe is negated T_CHK+1+tmo_limit cycles after it was asserted, and the response has rsp_err=1. All other accesses return rsp_err=0.
- R12: req_ready is high only when idle, and a request while busy is ignored. Each accepted request yields exactly one single-cycle rsp_valid, at which point the selects are already negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 5 | {cs1 select, cs0 select, address[2:0]} |
| req_wdata | input | 8 | Write byte |
| tmo_limit | input | 16 | Wait cycles allowed before abort |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| rsp_err | output | 1 | Last access aborted by the wait timeout |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Register address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dmack_n | output | 1 | DMA acknowledge, held negated |
| ata_dd_o | output | 8 | Low data byte out |
| ata_dd_oe | output | 1 | Output enable for ata_dd_o |
| ata_dd_i | input | 8 | Low data byte in |
| ata_iordy | input | 1 | Device ready line |

## Verification
A wrong phase or counter value shows up at the ports within one access. A strobe moved by even one cycle breaks the exact setup and pulse counts measured from the acceptance edge. A lost wait or a false wait changes the strobe length, either by hundreds of cycles or by T_PULSE against the wait length. A mistimed capture is caught by a data bus that carries a different byte until the ready line rises. A wrong hold counter shows at once as the output enable running past the T_DHOLD window, or as the selects dropping before T_HOLD.

// File: rtl/ata_reg_pkg.sv
package ata_reg_pkg;
  localparam int CS_LINES = 2;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_WAIT   = 3'd3,
    PH_END    = 3'd4
  } cyc_phase_t;
endpackage

// File: rtl/ata_sync.sv
module ata_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ata_reg_seq.sv
module ata_reg_seq
  import ata_reg_pkg::*;
#(
  parameter int T_SETUP = 250,
  parameter int T_PULSE = 75,
  parameter int T_CHK   = 9,
  parameter int T_HOLD  = 225,
  parameter int T_REC   = 225,
  parameter int T_CYCLE = 500,
  parameter int T_DHOLD = 10,
  parameter int TMO_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             wr,
  input  logic             iordy_s,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             idle_o,
  output logic             bus_o,
  output logic             strobe_o,
  output logic             drive_o,
  output logic             cap_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int END_MIN = (T_HOLD > (T_REC - T_SETUP)) ? T_HOLD : (T_REC - T_SETUP);
  localparam int MAX_A   = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int CNT_MAX = (MAX_A > END_MIN) ? MAX_A : END_MIN;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int TCW     = $clog2(T_CYCLE + 1);

  cyc_phase_t       state, nxt;
  logic [CW-1:0]    cnt, cnt_n;
  logic [TCW-1:0]   tcnt, tcnt_n;
  logic [TMO_W-1:0] wcnt, wcnt_n;
  logic             strobe_q, bus_q, drive_q, err_q, done_q;
  logic             drive_n, err_n, done_n, cap_n;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    nxt     = state;
    cnt_n   = (cnt == CW'(CNT_MAX)) ? cnt : cnt + CW'(1);
    tcnt_n  = (tcnt >= TCW'(T_CYCLE - 1)) ? tcnt : tcnt + TCW'(1);
    wcnt_n  = wcnt;
    drive_n = drive_q;
    err_n   = err_q;
    done_n  = 1'b0;
    cap_n   = 1'b0;
    unique case (state)
      PH_IDLE: begin
        cnt_n  = '0;
        tcnt_n = '0;
        if (req_fire) begin
          nxt   = PH_SETUP;
          err_n = 1'b0;
        end
      end
      PH_SETUP: begin
        if (cnt == CW'(T_SETUP - 1)) begin
          nxt     = PH_STROBE;
          cnt_n   = '0;
          drive_n = wr;
        end
      end
      PH_STROBE: begin
        if (cnt == CW'(T_CHK - 1) && !iordy_s) begin
          nxt    = PH_WAIT;
          wcnt_n = '0;
        end else if (cnt == CW'(T_PULSE - 1)) begin
          nxt   = PH_END;
          cnt_n = '0;
          cap_n = !wr;
        end
      end
      PH_WAIT: begin
        if (iordy_s && cnt >= CW'(T_PULSE - 1)) begin
          nxt   = PH_END;
          cnt_n = '0;
          cap_n = !wr;
        end else if (!iordy_s && wcnt == tmo_limit) begin
          nxt   = PH_END;
          cnt_n = '0;
          err_n = 1'b1;
        end else if (wcnt != tmo_limit) begin
          wcnt_n = wcnt + TMO_W'(1);
        end
      end
      PH_END: begin
        drive_n = drive_q && (cnt < CW'(T_DHOLD - 1));
        if (cnt >= CW'(END_MIN - 1) && tcnt >= TCW'(T_CYCLE - 1)) begin
          nxt     = PH_IDLE;
          done_n  = 1'b1;
          drive_n = 1'b0;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign cnt_en = (state != PH_IDLE) || req_fire;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      tcnt     <= '0;
      wcnt     <= '0;
      strobe_q <= 1'b0;
      bus_q    <= 1'b0;
      drive_q  <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state    <= nxt;
      strobe_q <= (nxt == PH_STROBE) || (nxt == PH_WAIT);
      bus_q    <= (nxt != PH_IDLE);
      drive_q  <= drive_n;
      err_q    <= err_n;
      done_q   <= done_n;
      if (cnt_en) begin
        cnt  <= cnt_n;
        tcnt <= tcnt_n;
        wcnt <= wcnt_n;
      end
    end
  end

  assign idle_o   = (state == PH_IDLE);
  assign bus_o    = bus_q;
  assign strobe_o = strobe_q;
  assign drive_o  = drive_q;
  assign cap_o    = cap_n;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R12: completion is a single-cycle pulse
  a_r12_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R12: a new access only starts from idle
  a_r12_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_SETUP && cnt == '0) |-> $past(state) == PH_IDLE);
  // R5: the strobe stays asserted while waiting for the device
  a_r5_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_WAIT) |-> strobe_q);
  // R11: the error flag only rises out of a wait
  a_r11_err_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(state) == PH_WAIT);
  // R4: a strobe that ends without error lasted the minimum pulse
  a_r4_pulse_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strobe_q) && !err_q) |-> $past(cnt) >= CW'(T_PULSE - 1));
endmodule

// File: rtl/ata_reg_dp.sv
module ata_reg_dp
  import ata_reg_pkg::*;
#(
  parameter int DA_W   = 3,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       req_write,
  input  logic [CS_LINES+DA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic                       bus_q,
  input  logic                       strobe_q,
  input  logic                       drive_q,
  input  logic                       cap,
  input  logic [DATA_W-1:0]          dd_i,
  output logic                       wr_o,
  output logic [CS_LINES-1:0]        cs_n_o,
  output logic [DA_W-1:0]            da_o,
  output logic                       dior_n_o,
  output logic                       diow_n_o,
  output logic [DATA_W-1:0]          dd_o,
  output logic                       dd_oe_o,
  output logic [DATA_W-1:0]          rdata_o
);
  logic                wr_q;
  logic [CS_LINES-1:0] sel_q;
  logic [DA_W-1:0]     da_q;
  logic [DATA_W-1:0]   wdat_q, rdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      sel_q  <= '0;
      da_q   <= '0;
      wdat_q <= '0;
    end else if (load) begin
      wr_q   <= req_write;
      sel_q  <= req_addr[CS_LINES+DA_W-1:DA_W];
      da_q   <= req_addr[DA_W-1:0];
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdat_q <= '0;
    else if (cap) rdat_q <= dd_i;
  end

  assign wr_o     = wr_q;
  assign cs_n_o   = ~({CS_LINES{bus_q}} & sel_q);
  assign da_o     = bus_q ? da_q : '0;
  assign dior_n_o = ~(strobe_q & ~wr_q);
  assign diow_n_o = ~(strobe_q & wr_q);
  assign dd_oe_o  = drive_q;
  assign dd_o     = drive_q ? wdat_q : '0;
  assign rdata_o  = rdat_q;

  // R1: selects and address do not move during an access
  a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_q && $past(bus_q)) |-> ($stable(cs_n_o) && $stable(da_o)));
  // R10: only a write ever drives the data bus
  a_r10_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe_o |-> wr_q);
  // R10: the data bus is released while idle
  a_r10_oe_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_q |-> !dd_oe_o);
endmodule

// File: rtl/ata_reg_cycle_gen.sv
module ata_reg_cycle_gen
  import ata_reg_pkg::*;
#(
  parameter int DA_W        = 3,
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int T_SETUP     = 250,
  parameter int T_PULSE     = 75,
  parameter int T_CHK       = 9,
  parameter int T_HOLD      = 225,
  parameter int T_REC       = 225,
  parameter int T_CYCLE     = 500,
  parameter int T_DHOLD     = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [CS_LINES+DA_W-1:0] req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [TMO_W-1:0]         tmo_limit,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_err,
  output logic                     ata_cs0_n,
  output logic                     ata_cs1_n,
  output logic [DA_W-1:0]          ata_da,
  output logic                     ata_dior_n,
  output logic                     ata_diow_n,
  output logic                     ata_dmack_n,
  output logic [DATA_W-1:0]        ata_dd_o,
  output logic                     ata_dd_oe,
  input  logic [DATA_W-1:0]        ata_dd_i,
  input  logic                     ata_iordy
);
  logic                rst_n_i;
  logic                iordy_s;
  logic                idle, bus_q, strobe_q, drive_q, cap, wr;
  logic                req_fire;
  logic [CS_LINES-1:0] cs_n;

  ata_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_i)
  );

  ata_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n_i), .d(ata_iordy), .q(iordy_s)
  );

  assign req_fire  = req_valid && idle;
  assign req_ready = idle;

  ata_reg_seq #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_CHK(T_CHK), .T_HOLD(T_HOLD),
    .T_REC(T_REC), .T_CYCLE(T_CYCLE), .T_DHOLD(T_DHOLD), .TMO_W(TMO_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_i), .req_fire(req_fire), .wr(wr),
    .iordy_s(iordy_s), .tmo_limit(tmo_limit),
    .idle_o(idle), .bus_o(bus_q), .strobe_o(strobe_q), .drive_o(drive_q),
    .cap_o(cap), .done_o(rsp_valid), .err_o(rsp_err)
  );

  ata_reg_dp #(.DA_W(DA_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n_i), .load(req_fire), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_q(bus_q),
    .strobe_q(strobe_q), .drive_q(drive_q), .cap(cap), .dd_i(ata_dd_i),
    .wr_o(wr), .cs_n_o(cs_n), .da_o(ata_da), .dior_n_o(ata_dior_n),
    .diow_n_o(ata_diow_n), .dd_o(ata_dd_o), .dd_oe_o(ata_dd_oe),
    .rdata_o(rsp_rdata)
  );

  assign ata_cs1_n   = cs_n[1];
  assign ata_cs0_n   = cs_n[0];
  assign ata_dmack_n = 1'b1;

  // R3: read and write strobes are never asserted together
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(!ata_dior_n && !ata_diow_n));
  // R1: a strobe only occurs with a chip select asserted
  a_r1_strobe_has_cs: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));
  // R12: the response never coincides with an asserted select
  a_r12_rsp_bus_free: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> (ata_cs0_n && ata_cs1_n));
endmodule

// File: tb/tb_ata_reg_cycle_gen.sv
module tb_ata_reg_cycle_gen;
  localparam int T_SETUP = 250;
  localparam int T_PULSE = 75;
  localparam int T_CHK   = 9;
  localparam int T_HOLD  = 225;
  localparam int T_REC   = 225;
  localparam int T_CYCLE = 500;
  localparam int T_DHOLD = 10;
  localparam int SYNCL   = 2;
  localparam int WDOG    = 190000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [4:0] req_addr;
  logic [7:0] req_wdata;
  logic [15:0] tmo_limit;
  logic req_ready, rsp_valid, rsp_err;
  logic [7:0] rsp_rdata;
  logic ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dmack_n, ata_dd_oe;
  logic [2:0] ata_da;
  logic [7:0] ata_dd_o, ata_dd_i;
  logic ata_iordy;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;
  longint prev_abs_n = -1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ata_reg_cycle_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .tmo_limit(tmo_limit), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
    .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dmack_n(ata_dmack_n), .ata_dd_o(ata_dd_o), .ata_dd_oe(ata_dd_oe),
    .ata_dd_i(ata_dd_i), .ata_iordy(ata_iordy)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // mode 0: ready high, 1: short low pulse before the check, 2: long wait, 3: never ready
  function automatic int exp_strobe_len(input int mode, input int wl, input int tmo);
    int w;
    case (mode)
      2: begin
        w = wl + SYNCL + 1;
        return (w > T_PULSE) ? w : T_PULSE;
      end
      3: return T_CHK + 1 + tmo;
      default: return T_PULSE;
    endcase
  endfunction

  task automatic run_txn(input bit wr, input logic [4:0] addr, input logic [7:0] wd,
                         input logic [7:0] rv, input int mode, input int wl, input bit spam);
    int k, ks, kn, kd;
    int bad_addr, bad_oe, bad_dmack, bad_hs;
    bit strobe_low, other_low, exp_oe;
    longint abs_s, abs_n;
    k = 0; ks = -1; kn = -1; kd = -1;
    bad_addr = 0; bad_oe = 0; bad_dmack = 0; bad_hs = 0;
    abs_s = 0; abs_n = 0;
    @(negedge clk);
    check(req_ready === 1'b1, "R12 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    ata_dd_i = ~rv;
    ata_iordy = (mode >= 2) ? 1'b0 : 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = addr ^ 5'h07; req_wdata = ~wd;
    while (kd < 0 && k < 6000) begin
      if (ata_dmack_n !== 1'b1) bad_dmack++;
      if (rsp_valid) kd = k;
      else begin
        if (ata_cs1_n !== ~addr[4] || ata_cs0_n !== ~addr[3] || ata_da !== addr[2:0]) bad_addr++;
        if (req_ready !== 1'b0) bad_hs++;
      end
      strobe_low = wr ? !ata_diow_n : !ata_dior_n;
      other_low  = wr ? !ata_dior_n : !ata_diow_n;
      if (other_low) bad_hs++;
      if (strobe_low && ks < 0) begin ks = k; abs_s = cyc; end
      if (!strobe_low && ks >= 0 && kn < 0) begin kn = k; abs_n = cyc; end
      if (strobe_low && kn >= 0) bad_hs++;
      exp_oe = wr && ks >= 0 && (kn < 0 || k < kn + T_DHOLD);
      if (ata_dd_oe !== exp_oe || (exp_oe && ata_dd_o !== wd)) bad_oe++;
      if (ks == k) begin
        if (mode != 2) ata_dd_i = rv;
        if (mode == 1) ata_iordy = 1'b0;
      end
      if (mode == 1 && ks >= 0 && k == ks + 3) ata_iordy = 1'b1;
      if (mode == 2 && ks >= 0 && k == ks + wl) begin ata_iordy = 1'b1; ata_dd_i = rv; end
      if (spam && k == 20) begin req_valid = 1'b1; req_addr = ~addr; end
      if (spam && k == 200) req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    check(kd >= 0, "R12 response seen", kd, 1);
    check(ks == T_SETUP, "R3 strobe after setup", ks, T_SETUP);
    check((kn - ks) == exp_strobe_len(mode, wl, int'(tmo_limit)),
          (mode == 3) ? "R11 timeout strobe length" :
          (mode == 2) ? "R5 wait strobe length" :
          (mode == 1) ? "R6 short low no wait" : "R4 strobe length",
          kn - ks, exp_strobe_len(mode, wl, int'(tmo_limit)));
    check((kd - kn) >= T_HOLD, "R8 address hold", kd - kn, T_HOLD);
    check(kd >= T_CYCLE, "R9 full cycle", kd, T_CYCLE);
    check(bad_addr == 0, "R1 address and selects", bad_addr, 0);
    check(bad_oe == 0, "R10 data drive window", bad_oe, 0);
    check(bad_dmack == 0, "R2 dmack negated", bad_dmack, 0);
    check(bad_hs == 0, "R12 busy handshake and strobes", bad_hs, 0);
    check(rsp_err == (mode == 3), "R11 error flag", rsp_err, (mode == 3));
    if (!wr && mode != 3) check(rsp_rdata == rv, "R7 read capture", rsp_rdata, rv);
    if (prev_abs_n >= 0) check((abs_s - prev_abs_n) >= T_REC, "R8 recovery", abs_s - prev_abs_n, T_REC);
    prev_abs_n = abs_n;
    check(rsp_valid === 1'b0 && ata_cs0_n === 1'b1 && ata_cs1_n === 1'b1,
          "R12 single response, bus idle", rsp_valid, 0);
    if (spam) begin
      repeat (4) @(negedge clk);
      check(req_ready === 1'b1 && ata_cs0_n && ata_cs1_n, "R12 busy request ignored", req_ready, 1);
    end
    ata_iordy = 1'b1;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: actual %0d expected below %0d", cyc, WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0a7a_5eed));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; tmo_limit = 16'd1000; ata_dd_i = '0; ata_iordy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ata_cs0_n && ata_cs1_n && ata_da == 3'd0, "R1 reset selects idle", {ata_cs1_n, ata_cs0_n}, 3);
    check(ata_dior_n && ata_diow_n && !ata_dd_oe, "R10 reset bus quiet", ata_dd_oe, 0);
    check(ata_dmack_n === 1'b1, "R2 reset dmack", ata_dmack_n, 1);
    check(req_ready && !rsp_valid, "R12 reset handshake", req_ready, 1);

    // directed corners
    run_txn(1'b1, 5'b10_101, 8'hA5, 8'h00, 0, 0, 1'b0);
    run_txn(1'b0, 5'b01_011, 8'h00, 8'h3C, 0, 0, 1'b0);
    run_txn(1'b0, 5'b10_111, 8'h00, 8'hC3, 1, 0, 1'b0);
    run_txn(1'b0, 5'b01_000, 8'h00, 8'h5A, 2, 250, 1'b0);
    run_txn(1'b1, 5'b10_010, 8'h7E, 8'h00, 2, 40, 1'b0);
    tmo_limit = 16'd100;
    run_txn(1'b0, 5'b01_110, 8'h00, 8'h99, 3, 0, 1'b0);
    tmo_limit = 16'd0;
    run_txn(1'b1, 5'b10_001, 8'h11, 8'h00, 3, 0, 1'b0);
    tmo_limit = 16'd1000;
    run_txn(1'b1, 5'b01_100, 8'hE7, 8'h00, 0, 0, 1'b1);

    // random mix
    for (int i = 0; i < 24; i++) begin
      bit wr;
      logic [4:0] a;
      int mode, wl;
      wr   = 1'($urandom % 2);
      a    = {(($urandom % 2) != 0) ? 2'b10 : 2'b01, 3'($urandom % 8)};
      mode = int'($urandom % 3);
      wl   = 80 + int'($urandom % 200);
      run_txn(wr, a, 8'($urandom), 8'($urandom), mode, wl, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule